// File: doc/BRIEF.md
# Two-Wire Memory Slave Front-End

This block is the bus-facing half of a two-wire serial memory of 8192 bytes. It oversamples the serial clock and data lines on the system clock and finds the bus conditions that open and close a transfer. It collects the addressing byte and compares it with a fixed type code and three strap pins. It answers on the open-drain data line by asserting an output that pulls the line low. The storage array sits outside the block. Written bytes leave as single-cycle strobes carrying an address. Read bytes are fetched through a combinational port that is addressed by the block's current pointer.

A write transfer consists of the addressing byte, two pointer bytes and then any number of data bytes. Each data byte is placed at the pointer, and the pointer then advances. A read transfer streams bytes from the pointer. A random read is made by loading the pointer with a write header and then sending a repeated start followed by a read header.

Top module: `twi_mem_slave`

## Requirements
- R1: A start is seen when SDA falls while SCL is high, and a stop is seen when SDA rises while SCL is high. The block changes its pull-low output only while the sampled SCL is low.
- R2: From reset and after any stop, the block leaves SDA released and gives no acknowledge until a start has been seen.
- R3: The addressing byte is taken MSB first. Bits 7..4 must be 1010, bits 3..1 must equal sel_i[2:0], and bit 0 selects the direction (1 = read, 0 = write). On a match, SDA is pulled low for the ninth clock.
- R4: On a type or select mismatch, no acknowledge is given and the block ignores the bus until the next start.
- R5: After a write header, the block receives two pointer bytes and acknowledges each one. The first holds pointer bits 12..8 in its bits 4..0. The second holds pointer bits 7..0.
- R6: If bits 7..5 of the first pointer byte are not all zero, the block gives no acknowledge and ignores the bus until the next start.
- R7: Each data byte that follows the pointer bytes is acknowledged. It produces a one-cycle wr_valid_o pulse with wr_addr_o equal to the pointer and wr_data_o equal to the byte. The pointer then advances by one.
- R8: After a read header, the block sends rd_data_i for address rd_addr_o MSB first and then releases SDA. After a master acknowledge it sends the next byte from the advanced pointer. After a missing acknowledge it drives nothing more.
- R9: The pointer wraps from 0x1FFF to 0x0000, on reads and on writes alike.
- R10: A repeated start in any state restarts reception of the addressing byte and keeps the pointer. A stop in any state returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sel_i | input | 3 | Strap pins compared with addressing bits 3..1 |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 13 | Target address of the written byte |
| wr_data_o | output | 8 | Written byte |
| rd_addr_o | output | 13 | Current pointer, address of the next byte read |
| rd_data_i | input | 8 | Memory byte at rd_addr_o |

## Verification
The bench clocks a header byte with no start before it. A block that fails to wait for a start would acknowledge that byte. It sends a header with the wrong strap bits, and then a first pointer byte whose top bits are set. A block that skips either check would acknowledge there or produce write strobes. It loads the pointer with 0x1FFF and reads and writes across the end of the array. A carry that leaks past bit 12, or a pointer that fails to advance, shows up as the wrong byte or the wrong address. It also clocks on after a master withholds its acknowledge. A block that keeps driving data would pull the line low in the bytes that follow.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int MEM_AW = 13;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_PTR_HI, ST_PTR_LO, ST_WDATA, ST_RDATA
  } twi_state_t;

  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
  endfunction

  function automatic logic hi_ok(input logic [7:0] b);
    return (b >> (MEM_AW - 8)) == 8'd0;
  endfunction

  function automatic logic [MEM_AW-1:0] addr_next(input logic [MEM_AW-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign ev_rise  = scl_s & ~scl_q;
  assign ev_fall  = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        sel_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [MEM_AW-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [MEM_AW-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int HI_W = MEM_AW - 8;

  logic [1:0] line_s;
  logic scl_s, sda_s;
  logic ev_rise, ev_fall, ev_start, ev_stop;

  twi_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  twi_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop)
  );

  twi_state_t        state, after;
  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic              mack;
  logic              pull;
  logic [MEM_AW-1:0] ptr;

  // named events for the checks
  logic rx_state, ack_slot, dev_reject;
  assign rx_state   = (state != ST_IDLE) && (state != ST_RDATA);
  assign ack_slot   = ev_fall && !ev_start && !ev_stop && rx_state && (cnt == 4'd8);
  assign dev_reject = ack_slot && (state == ST_DEV) && !dev_match(sh, sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      after      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      mack       <= 1'b0;
      pull       <= 1'b0;
      ptr        <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (ev_start) begin
        state <= ST_DEV;
        cnt   <= '0;
        pull  <= 1'b0;
      end else if (ev_stop) begin
        state <= ST_IDLE;
        pull  <= 1'b0;
      end else if (state == ST_RDATA) begin
        if (ev_rise) begin
          if (cnt == 4'd8) mack <= ~sda_s;
          cnt <= cnt + 4'd1;
        end else if (ev_fall) begin
          if (cnt == 4'd8) begin
            pull <= 1'b0;
            ptr  <= addr_next(ptr);
          end else if (cnt == 4'd9) begin
            if (mack) begin
              sh   <= rd_data_i;
              pull <= ~rd_data_i[7];
              cnt  <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end else if (cnt != 4'd0) begin
            sh   <= {sh[6:0], 1'b1};
            pull <= ~sh[6];
          end
        end
      end else if (state != ST_IDLE) begin
        if (ev_rise) begin
          if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (ev_fall) begin
          if (cnt == 4'd8) begin
            case (state)
              ST_DEV: begin
                if (dev_match(sh, sel_i)) begin
                  pull  <= 1'b1;
                  after <= sh[0] ? ST_RDATA : ST_PTR_HI;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_PTR_HI: begin
                if (hi_ok(sh)) begin
                  pull  <= 1'b1;
                  ptr[MEM_AW-1:8] <= sh[HI_W-1:0];
                  after <= ST_PTR_LO;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_PTR_LO: begin
                pull     <= 1'b1;
                ptr[7:0] <= sh;
                after    <= ST_WDATA;
              end
              default: begin
                pull       <= 1'b1;
                wr_valid_o <= 1'b1;
                wr_addr_o  <= ptr;
                wr_data_o  <= sh;
                ptr        <= addr_next(ptr);
                after      <= ST_WDATA;
              end
            endcase
          end else if (cnt == 4'd9) begin
            cnt   <= '0;
            state <= after;
            if (after == ST_RDATA) begin
              sh   <= rd_data_i;
              pull <= ~rd_data_i[7];
            end else begin
              pull <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign sda_pull_o = pull;
  assign rd_addr_o  = ptr;

  p_pull_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_s)
    else $error("R1: pull output changed while SCL high");

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_o)
    else $error("R2: pull asserted while idle");

  p_reject_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reject |=> (state == ST_IDLE) && !sda_pull_o)
    else $error("R4: mismatched header not rejected");

  p_write_from_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> ($past(state) == ST_WDATA) && sda_pull_o)
    else $error("R7: write strobe outside data phase");

  p_wrap_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (rd_addr_o == addr_next(wr_addr_o)))
    else $error("R9: pointer did not advance after write");
endmodule

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_pull, wr_valid;
  logic [12:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_line = m_sda & ~sda_pull;

  int n_chk = 0, n_bad = 0, wl_n = 0;
  logic [12:0] wl_addr [0:31];
  logic [7:0]  wl_data [0:31];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction
  assign rd_data = memf(rd_addr);

  twi_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sel_i(SEL),
    .sda_pull_o(sda_pull), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  always @(posedge clk) if (wr_valid && wl_n < 32) begin
    wl_addr[wl_n] <= wr_addr;
    wl_data[wl_n] <= wr_data;
    wl_n <= wl_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    m_sda = 1; wt(HALF/2); m_scl = 1; wt(HALF); m_sda = 0; wt(HALF); m_scl = 0; wt(HALF/2);
  endtask

  task automatic b_stop();
    m_sda = 0; wt(HALF/2); m_scl = 1; wt(HALF); m_sda = 1; wt(HALF);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(HALF); m_scl = 1; wt(HALF); m_scl = 0;
    end
    m_sda = 1; wt(HALF); m_scl = 1; wt(HALF/2);
    ack = ~sda_line;
    wt(HALF/2); m_scl = 0;
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(HALF); m_scl = 1; wt(HALF/2); b[i] = sda_line; wt(HALF/2); m_scl = 0;
    end
    m_sda = ~give_ack; wt(HALF); m_scl = 1; wt(HALF); m_scl = 0; wt(2); m_sda = 1;
  endtask

  function automatic logic [7:0] hdr(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic set_ptr(input logic [12:0] a);
    bit ak;
    b_start();
    send(hdr(SEL, 0), ak); chk(ak, "R3 header ack", ak, 1);
    send({3'b000, a[12:8]}, ak); chk(ak, "R5 ptr hi ack", ak, 1);
    send(a[7:0], ak); chk(ak, "R5 ptr lo ack", ak, 1);
  endtask

  task automatic t_reset();
    chk(sda_pull == 0, "R2 reset pull", sda_pull, 0);
    chk(wr_valid == 0, "R2 reset strobe", wr_valid, 0);
  endtask

  task automatic t_no_start();
    bit ak;
    m_scl = 0; wt(HALF);
    send(hdr(SEL, 0), ak);
    chk(!ak, "R2 no ack before start", ak, 0);
    m_sda = 1; m_scl = 1; wt(HALF);
  endtask

  task automatic t_bad_select();
    bit ak;
    b_start();
    send(hdr(3'b001, 0), ak); chk(!ak, "R4 wrong select nack", ak, 0);
    send(8'h00, ak); chk(!ak, "R4 ignored after reject", ak, 0);
    b_stop();
    b_start();
    send(8'hB0 | {4'h0, SEL, 1'b0}, ak); chk(!ak, "R4 wrong type nack", ak, 0);
    b_stop();
  endtask

  task automatic t_write();
    bit ak; int base;
    base = wl_n;
    set_ptr(13'h0120);
    send(8'hAA, ak); chk(ak, "R7 data ack", ak, 1);
    send(8'h55, ak); chk(ak, "R7 data ack", ak, 1);
    send(8'hC3, ak); chk(ak, "R1 R7 data ack", ak, 1);
    b_stop(); wt(4);
    chk(wl_n == base + 3, "R7 strobe count", wl_n - base, 3);
    chk(wl_addr[base] == 13'h0120 && wl_data[base] == 8'hAA, "R7 first write", wl_data[base], 8'hAA);
    chk(wl_addr[base+2] == 13'h0122 && wl_data[base+2] == 8'hC3, "R7 third write", wl_addr[base+2], 13'h0122);
  endtask

  task automatic t_bad_high();
    bit ak; int base;
    base = wl_n;
    b_start();
    send(hdr(SEL, 0), ak); chk(ak, "R3 header ack", ak, 1);
    send(8'h20, ak); chk(!ak, "R6 ptr hi reject", ak, 0);
    send(8'h00, ak); chk(!ak, "R6 ignored after reject", ak, 0);
    send(8'h77, ak);
    b_stop(); wt(4);
    chk(wl_n == base, "R6 no write strobe", wl_n - base, 0);
  endtask

  task automatic t_read_seq();
    bit ak; logic [7:0] d;
    set_ptr(13'h0310);
    b_start();
    send(hdr(SEL, 1), ak); chk(ak, "R10 repeated start header ack", ak, 1);
    recv(1, d); chk(d == memf(13'h0310), "R8 read byte 0", d, memf(13'h0310));
    recv(1, d); chk(d == memf(13'h0311), "R8 read byte 1", d, memf(13'h0311));
    recv(0, d); chk(d == memf(13'h0312), "R8 read byte 2", d, memf(13'h0312));
    recv(0, d); chk(d == 8'hFF, "R8 silent after nack", d, 8'hFF);
    b_stop();
  endtask

  task automatic t_wrap();
    bit ak; logic [7:0] d; int base;
    set_ptr(13'h1FFF);
    b_start();
    send(hdr(SEL, 1), ak); chk(ak, "R3 read header ack", ak, 1);
    recv(1, d); chk(d == memf(13'h1FFF), "R9 read at top", d, memf(13'h1FFF));
    recv(0, d); chk(d == memf(13'h0000), "R9 read wraps", d, memf(13'h0000));
    b_stop();
    base = wl_n;
    set_ptr(13'h1FFF);
    send(8'h11, ak); send(8'h22, ak);
    b_stop(); wt(4);
    chk(wl_addr[base] == 13'h1FFF, "R9 write at top", wl_addr[base], 13'h1FFF);
    chk(wl_addr[base+1] == 13'h0000, "R9 write wraps", wl_addr[base+1], 0);
  endtask

  task automatic t_stop_mid();
    bit ak; int base;
    base = wl_n;
    b_start();
    send(hdr(SEL, 0), ak);
    b_stop();
    m_scl = 0; wt(HALF);
    send(8'h00, ak); chk(!ak, "R10 idle after stop", ak, 0);
    send(8'h99, ak); chk(!ak, "R10 idle after stop", ak, 0);
    m_sda = 1; m_scl = 1; wt(HALF);
    chk(wl_n == base, "R10 no write after stop", wl_n - base, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wt(5); rst_n = 1; wt(5);
    t_reset();
    t_no_start();
    t_bad_select();
    t_write();
    t_bad_high();
    t_read_seq();
    t_wrap();
    t_stop_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule